// File: doc/BRIEF.md
# NAPOT-Aware Translation Cache

This block is a small, fully associative cache of address translations for a 39-bit virtual address space that uses a three-level page table. Each entry maps one of four page sizes:

- an ordinary 4 KiB page,
- a 2 MiB superpage,
- a 1 GiB superpage,
- a 64 KiB naturally aligned contiguous region. This region is marked in the page-table entry by a contiguity flag.

A page walker, which lies outside this block, offers each leaf entry on the fill port. The block checks the entry before storing it. An illegal entry raises a fault pulse and leaves the cache unchanged.

A contiguous 64 KiB entry is stored with the four lowest page-number bits cleared and is flagged as a 64 KiB entry. A lookup into any of the sixteen 4 KiB pages of that region therefore hits the single entry. On such a hit, the four lowest physical page bits are rebuilt from the lookup address. The lookup port takes a virtual address and an address-space identifier. One cycle later it returns a hit flag, a 56-bit physical address and the low byte of the entry's flags. A flush input empties the whole cache in one cycle.

Top module: `napot_tlb`

## Requirements
- R1: Reset and flush both leave every entry invalid, so a lookup after either returns hit_o = 0. A flush takes effect one cycle after it is asserted. When flush and a fill arrive in the same cycle, the fill is not stored.
- R2: A fill is illegal in each of these cases:
  - V (bit 0) is 0;
  - R (bit 1) is 0 while W (bit 2) is 1;
  - any reserved bit 62:54 is set;
  - the level code is 3.

  Level codes are 0 for 4 KiB, 1 for 2 MiB and 2 for 1 GiB. For an illegal fill, fill_fault_o is 1 in the cycle after the fill, and nothing is stored.
- R3: The contiguity flag sits at bit 63. A fill with this flag set is illegal in each of these cases:
  - the parameter NAPOT_EN is 0;
  - the entry is not a leaf, meaning R and X (bit 3) are both 0;
  - the level code is not 0;
  - PPN bits 3:0 (entry bits 13:10) are not 4'b1000.

  In all other cases the flagged fill is accepted as a 64 KiB entry.
- R4: A 64 KiB entry hits for any lookup address whose VPN bits 26:4 equal the stored VPN bits 26:4. VPN bits 3:0, which are address bits 15:12, are ignored.
- R5: On a 64 KiB hit, paddr_o bits 15:12 equal the lookup address bits 15:12. All higher bits come from the stored PPN.
- R6: A 4 KiB entry hits only when all 27 VPN bits match. Its paddr_o is the stored PPN (bits 53:10) joined with address bits 11:0.
- R7: Superpages match on fewer VPN bits:
  - a 2 MiB entry compares VPN bits 26:9 and takes physical address bits 20:12 from the lookup address;
  - a 1 GiB entry compares VPN bits 26:18 and takes physical address bits 29:12 from the lookup address.
- R8: A hit needs the entry's stored address-space identifier to equal lookup_asid_i. The one exception is an entry whose G bit (bit 5) is set, which matches any identifier.
- R9: A legal fill takes the lowest-index invalid entry. When all 8 entries are valid, it takes the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one on each fill that finds the cache full.
- R10: When several entries match a lookup, the lowest-index entry supplies paddr_o and perm_o.
- R11: hit_o, paddr_o and perm_o (entry bits 7:0) are registered. They reflect the lookup presented in the previous cycle. They are all 0 in the cycle after a cycle with no lookup, and after a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate every entry |
| fill_valid_i | input | 1 | Fill request |
| fill_pte_i | input | 64 | Leaf page-table entry to store |
| fill_level_i | input | 2 | Level code of the entry: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_vpn_i | input | 27 | Virtual page number of the fill |
| fill_asid_i | input | 16 | Address-space identifier of the fill |
| fill_fault_o | output | 1 | Pulse: the previous cycle's fill was illegal |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vaddr_i | input | 39 | Virtual address to translate |
| lookup_asid_i | input | 16 | Address-space identifier of the lookup |
| hit_o | output | 1 | Previous lookup hit |
| paddr_o | output | 56 | Translated physical address |
| perm_o | output | 8 | Entry flag byte (V, R, W, X, U, G, A, D) |

## Verification
Suppose a stored VPN is not masked, or the 64 KiB flag is lost. A lookup into the same region with different address bits 15:12 then misses, or it returns the stored low PPN nibble in place of the lookup's bits. That difference shows at hit_o and paddr_o in the cycle after the lookup.

A wrong valid bit or a wrong round-robin pointer shows up only after a later eviction. The error becomes visible when the entry that should have survived misses, or the evicted entry still hits. For that reason the bench keeps a full model of the stored contents and compares every lookup against it.

A wrong legality decision shows at fill_fault_o one cycle after the fill. A second instance with contiguity support disabled checks the same fills against the other legality rule.

// File: rtl/napot_tlb_pkg.sv
package napot_tlb_pkg;
    localparam int LVL_BITS   = 9;
    localparam int LEVELS     = 3;
    localparam int VPN_W      = LVL_BITS * LEVELS;
    localparam int OFF_W      = 12;
    localparam int VA_W       = VPN_W + OFF_W;
    localparam int PPN_W      = 44;
    localparam int PA_W       = PPN_W + OFF_W;
    localparam int ASID_W     = 16;
    localparam int NAPOT_BITS = 4;
    localparam logic [NAPOT_BITS-1:0] NAPOT_CODE = 4'b1000;

    typedef enum logic [1:0] {
        LVL_4K  = 2'd0,
        LVL_2M  = 2'd1,
        LVL_1G  = 2'd2,
        LVL_BAD = 2'd3
    } level_e;

    typedef struct packed {
        logic              contig;
        logic [8:0]        rsvd;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        sw;
        logic              d;
        logic              a;
        logic              g;
        logic              u;
        logic              x;
        logic              w;
        logic              r;
        logic              v;
    } pte_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        level_e            lvl;
        logic              is64k;
        pte_t              pte;
    } entry_t;

    // Bits of the VPN that take part in the tag compare.
    function automatic logic [VPN_W-1:0] care_mask(level_e lvl, logic is64k);
        logic [VPN_W-1:0] m;
        m = '1;
        case (lvl)
            LVL_2M:  m[LVL_BITS-1:0]   = '0;
            LVL_1G:  m[2*LVL_BITS-1:0] = '0;
            default: if (is64k) m[NAPOT_BITS-1:0] = '0;
        endcase
        return m;
    endfunction

    // Physical page number after filling the low fields from the lookup VPN.
    function automatic logic [PPN_W-1:0] merge_ppn(logic [PPN_W-1:0] ppn, level_e lvl,
                                                   logic is64k, logic [VPN_W-1:0] vpn);
        logic [PPN_W-1:0] p;
        p = ppn;
        case (lvl)
            LVL_2M:  p[LVL_BITS-1:0]   = vpn[LVL_BITS-1:0];
            LVL_1G:  p[2*LVL_BITS-1:0] = vpn[2*LVL_BITS-1:0];
            default: if (is64k) p[NAPOT_BITS-1:0] = vpn[NAPOT_BITS-1:0];
        endcase
        return p;
    endfunction
endpackage

// File: rtl/napot_tlb_check.sv
module napot_tlb_check
    import napot_tlb_pkg::*;
#(
    parameter bit NAPOT_EN = 1'b1
) (
    input  pte_t   pte,
    input  level_e level,
    output logic   legal,
    output logic   is64k
);
    logic leaf;
    logic base_bad;
    logic napot_shape;

    always_comb begin
        leaf        = pte.r | pte.x;
        base_bad    = !pte.v || (!pte.r && pte.w) || (|pte.rsvd) || (level == LVL_BAD);
        napot_shape = leaf && (level == LVL_4K) && (pte.ppn[NAPOT_BITS-1:0] == NAPOT_CODE);
        is64k       = NAPOT_EN && pte.contig && napot_shape && !base_bad;
        legal       = !base_bad && (!pte.contig || is64k);
    end
endmodule

// File: rtl/napot_tlb_match.sv
module napot_tlb_match
    import napot_tlb_pkg::*;
(
    input  entry_t            ent,
    input  logic              ent_valid,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic              hit
);
    logic [VPN_W-1:0] mask;
    logic             tag_ok;
    logic             asid_ok;

    always_comb begin
        mask    = care_mask(ent.lvl, ent.is64k);
        tag_ok  = ((ent.vpn ^ vpn) & mask) == '0;
        asid_ok = ent.pte.g || (ent.asid == asid);
        hit     = ent_valid && tag_ok && asid_ok;
    end
endmodule

// File: rtl/napot_tlb_repl.sv
module napot_tlb_repl #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim = any_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !any_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/napot_tlb.sv
module napot_tlb
    import napot_tlb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter bit NAPOT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              fill_valid_i,
    input  logic [63:0]       fill_pte_i,
    input  logic [1:0]        fill_level_i,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [ASID_W-1:0] fill_asid_i,
    output logic              fill_fault_o,
    input  logic              lookup_valid_i,
    input  logic [VA_W-1:0]   lookup_vaddr_i,
    input  logic [ASID_W-1:0] lookup_asid_i,
    output logic              hit_o,
    output logic [PA_W-1:0]   paddr_o,
    output logic [7:0]        perm_o
);
    localparam int IDX_W = $clog2(ENTRIES);

    entry_t             ents_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] wr_onehot;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   sel;
    logic               legal;
    logic               is64k;
    logic               commit;
    entry_t             new_ent;
    logic [VPN_W-1:0]   lu_vpn;
    logic               fault_q;
    logic               hit_q;
    logic               out64k_q;
    logic [PA_W-1:0]    paddr_q;
    logic [7:0]         perm_q;

    napot_tlb_check #(.NAPOT_EN(NAPOT_EN)) check_i (
        .pte   (pte_t'(fill_pte_i)),
        .level (level_e'(fill_level_i)),
        .legal (legal),
        .is64k (is64k)
    );

    napot_tlb_repl #(.ENTRIES(ENTRIES)) repl_i (
        .clk    (clk),
        .rst    (rst),
        .valid  (valid_q),
        .alloc  (commit),
        .victim (victim)
    );

    assign commit = fill_valid_i && legal && !flush_i;
    assign lu_vpn = lookup_vaddr_i[VA_W-1:OFF_W];

    always_comb begin
        new_ent.vpn   = fill_vpn_i;
        if (is64k) new_ent.vpn[NAPOT_BITS-1:0] = '0;
        new_ent.asid  = fill_asid_i;
        new_ent.lvl   = level_e'(fill_level_i);
        new_ent.is64k = is64k;
        new_ent.pte   = pte_t'(fill_pte_i);
        wr_onehot     = '0;
        if (commit) wr_onehot[victim] = 1'b1;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : gen_way
        napot_tlb_match match_i (
            .ent       (ents_q[g]),
            .ent_valid (valid_q[g]),
            .vpn       (lu_vpn),
            .asid      (lookup_asid_i),
            .hit       (hit_vec[g])
        );

        always_ff @(posedge clk) begin
            if (wr_onehot[g]) ents_q[g] <= new_ent;
        end
    end

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            fault_q  <= 1'b0;
            hit_q    <= 1'b0;
            out64k_q <= 1'b0;
            paddr_q  <= '0;
            perm_q   <= '0;
        end else begin
            if (flush_i) valid_q <= '0;
            else         valid_q <= valid_q | wr_onehot;
            fault_q <= fill_valid_i && !legal;
            if (lookup_valid_i && |hit_vec) begin
                hit_q    <= 1'b1;
                out64k_q <= ents_q[sel].is64k;
                paddr_q  <= {merge_ppn(ents_q[sel].pte.ppn, ents_q[sel].lvl,
                                       ents_q[sel].is64k, lu_vpn),
                             lookup_vaddr_i[OFF_W-1:0]};
                perm_q   <= fill_byte(ents_q[sel].pte);
            end else begin
                hit_q    <= 1'b0;
                out64k_q <= 1'b0;
                paddr_q  <= '0;
                perm_q   <= '0;
            end
        end
    end

    function automatic logic [7:0] fill_byte(pte_t p);
        return {p.d, p.a, p.g, p.u, p.x, p.w, p.r, p.v};
    endfunction

    assign fill_fault_o = fault_q;
    assign hit_o        = hit_q;
    assign paddr_o      = paddr_q;
    assign perm_o       = perm_q;
endmodule

// File: rtl/napot_tlb_sva.sv
module napot_tlb_sva
    import napot_tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               flush_i,
    input logic               fill_valid_i,
    input logic               lookup_valid_i,
    input logic [VA_W-1:0]    lookup_vaddr_i,
    input logic               fill_fault_o,
    input logic               hit_o,
    input logic [PA_W-1:0]    paddr_o,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] wr_onehot,
    input logic               out64k_q
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> valid_q == '0); // R1
    AST_MISS_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $past(flush_i, 2) && $past(lookup_valid_i) |-> !hit_o); // R1
    AST_FAULT_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        fill_fault_o |-> $past(fill_valid_i)); // R2
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        fill_fault_o |-> $past(wr_onehot) == '0); // R2
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_onehot)); // R9
    AST_NAPOT_LOW_PPN: assert property (@(posedge clk) disable iff (rst)
        hit_o && out64k_q |-> paddr_o[15:12] == $past(lookup_vaddr_i[15:12])); // R5
    AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(lookup_valid_i)); // R11
endmodule

bind napot_tlb napot_tlb_sva #(.ENTRIES(ENTRIES)) sva_i (
    .clk            (clk),
    .rst            (rst),
    .flush_i        (flush_i),
    .fill_valid_i   (fill_valid_i),
    .lookup_valid_i (lookup_valid_i),
    .lookup_vaddr_i (lookup_vaddr_i),
    .fill_fault_o   (fill_fault_o),
    .hit_o          (hit_o),
    .paddr_o        (paddr_o),
    .valid_q        (valid_q),
    .wr_onehot      (wr_onehot),
    .out64k_q       (out64k_q)
);

// File: tb/napot_tlb_tb.sv
`timescale 1ns/1ps
module napot_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic        fill_valid_i = 1'b0;
    logic [63:0] fill_pte_i = '0;
    logic [1:0]  fill_level_i = '0;
    logic [26:0] fill_vpn_i = '0;
    logic [15:0] fill_asid_i = '0;
    logic        lookup_valid_i = 1'b0;
    logic [38:0] lookup_vaddr_i = '0;
    logic [15:0] lookup_asid_i = '0;
    logic        fill_fault_o, hit_o, off_fault, off_hit;
    logic [55:0] paddr_o, off_paddr;
    logic [7:0]  perm_o, off_perm;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    napot_tlb dut_i (
        .clk(clk), .rst(rst), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
        .fill_pte_i(fill_pte_i), .fill_level_i(fill_level_i), .fill_vpn_i(fill_vpn_i),
        .fill_asid_i(fill_asid_i), .fill_fault_o(fill_fault_o),
        .lookup_valid_i(lookup_valid_i), .lookup_vaddr_i(lookup_vaddr_i),
        .lookup_asid_i(lookup_asid_i), .hit_o(hit_o), .paddr_o(paddr_o), .perm_o(perm_o));

    napot_tlb #(.NAPOT_EN(1'b0)) dut_off_i (
        .clk(clk), .rst(rst), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
        .fill_pte_i(fill_pte_i), .fill_level_i(fill_level_i), .fill_vpn_i(fill_vpn_i),
        .fill_asid_i(fill_asid_i), .fill_fault_o(off_fault),
        .lookup_valid_i(lookup_valid_i), .lookup_vaddr_i(lookup_vaddr_i),
        .lookup_asid_i(lookup_asid_i), .hit_o(off_hit), .paddr_o(off_paddr), .perm_o(off_perm));

    // Reference model of the stored contents
    logic [26:0] m_vpn  [8];
    logic [15:0] m_asid [8];
    logic [1:0]  m_lvl  [8];
    logic        m_64k  [8];
    logic [63:0] m_pte  [8];
    logic [7:0]  m_valid = '0;
    int          m_rr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit m_legal(logic [63:0] p, logic [1:0] lvl, bit en);
        if (!p[0]) return 0;
        if (!p[1] && p[2]) return 0;
        if (p[62:54] != 9'd0) return 0;
        if (lvl == 2'd3) return 0;
        if (p[63]) begin
            if (!en) return 0;
            if (!(p[1] || p[3])) return 0;
            if (lvl != 2'd0) return 0;
            if (p[13:10] != 4'b1000) return 0;
        end
        return 1;
    endfunction

    task automatic m_store(input logic [63:0] p, input logic [1:0] lvl,
                           input logic [26:0] vpn, input logic [15:0] asid);
        int slot;
        slot = -1;
        for (int i = 0; i < 8; i++) if (slot < 0 && !m_valid[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % 8;
        end
        m_64k[slot]  = p[63];
        m_vpn[slot]  = p[63] ? {vpn[26:4], 4'b0000} : vpn;
        m_lvl[slot]  = lvl;
        m_asid[slot] = asid;
        m_pte[slot]  = p;
        m_valid[slot] = 1'b1;
    endtask

    task automatic m_lookup(input logic [38:0] va, input logic [15:0] asid,
                            output bit h, output logic [55:0] pa, output logic [7:0] pm);
        logic [26:0] v;
        logic [43:0] ppn;
        bit          tag;
        v = va[38:12];
        h = 0; pa = '0; pm = '0;
        for (int i = 0; i < 8; i++) begin
            if (!h && m_valid[i]) begin
                case (m_lvl[i])
                    2'd1:    tag = v[26:9]  == m_vpn[i][26:9];
                    2'd2:    tag = v[26:18] == m_vpn[i][26:18];
                    default: tag = m_64k[i] ? v[26:4] == m_vpn[i][26:4] : v == m_vpn[i];
                endcase
                if (tag && (m_pte[i][5] || asid == m_asid[i])) begin
                    h   = 1;
                    ppn = m_pte[i][53:10];
                    if (m_lvl[i] == 2'd1)      ppn[8:0]  = v[8:0];
                    else if (m_lvl[i] == 2'd2) ppn[17:0] = v[17:0];
                    else if (m_64k[i])         ppn[3:0]  = va[15:12];
                    pa = {ppn, va[11:0]};
                    pm = m_pte[i][7:0];
                end
            end
        end
    endtask

    task automatic do_fill(input logic [63:0] p, input logic [1:0] lvl,
                           input logic [26:0] vpn, input logic [15:0] asid,
                           input bit with_flush, input string req);
        bit leg;
        @(negedge clk);
        fill_valid_i = 1'b1; fill_pte_i = p; fill_level_i = lvl;
        fill_vpn_i = vpn; fill_asid_i = asid; flush_i = with_flush;
        @(posedge clk);
        #1;
        leg = m_legal(p, lvl, 1'b1);
        check(fill_fault_o == !leg, req, "fill fault", 64'(fill_fault_o), 64'(!leg));
        check(off_fault == !m_legal(p, lvl, 1'b0), "R3", "fault with contiguity disabled",
              64'(off_fault), 64'(!m_legal(p, lvl, 1'b0)));
        if (with_flush) m_valid = '0;
        else if (leg)   m_store(p, lvl, vpn, asid);
        @(negedge clk);
        fill_valid_i = 1'b0; flush_i = 1'b0;
    endtask

    task automatic do_lookup(input logic [38:0] va, input logic [15:0] asid, input string req);
        bit          h;
        logic [55:0] pa;
        logic [7:0]  pm;
        m_lookup(va, asid, h, pa, pm);
        @(negedge clk);
        lookup_valid_i = 1'b1; lookup_vaddr_i = va; lookup_asid_i = asid;
        @(posedge clk);
        #1;
        check(hit_o == h,   req, "hit",   64'(hit_o),   64'(h));
        check(paddr_o == pa, req, "paddr", 64'(paddr_o), 64'(pa));
        check(perm_o == pm, req, "perm",  64'(perm_o),  64'(pm));
        @(negedge clk);
        lookup_valid_i = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        m_valid = '0;
    endtask

    function automatic logic [63:0] mk(bit n, logic [43:0] ppn, logic [7:0] fl);
        return {n, 9'd0, ppn, 2'b00, fl};
    endfunction

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] p;
        logic [26:0] vpn;
        logic [38:0] va;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        check(hit_o == 0 && fill_fault_o == 0 && paddr_o == 0, "R1", "reset outputs",
              64'(paddr_o), 64'd0);
        @(negedge clk); rst = 1'b0;
        do_lookup(39'h12_3456_7000, 16'd1, "R1");

        // R6: 4 KiB page, exact compare
        do_fill(mk(0, 44'hABC_DEF0, 8'h0B), 2'd0, 27'h123_4567, 16'd1, 0, "R6");
        do_lookup({27'h123_4567, 12'h5A5}, 16'd1, "R6");
        do_lookup({27'h123_4566, 12'h5A5}, 16'd1, "R6");
        // R11: no lookup means zero outputs
        @(posedge clk); #1;
        check(hit_o == 0 && paddr_o == 0 && perm_o == 0, "R11", "idle outputs",
              64'(hit_o), 64'd0);
        // R8: asid mismatch, global entry
        do_lookup({27'h123_4567, 12'h000}, 16'd2, "R8");
        do_fill(mk(0, 44'h777_0000, 8'h23), 2'd0, 27'h000_0042, 16'd9, 0, "R8");
        do_lookup({27'h000_0042, 12'h010}, 16'd3, "R8");
        // R7: superpages
        do_fill(mk(0, 44'h1234_5000, 8'h07), 2'd1, 27'h055_5000, 16'd1, 0, "R7");
        do_lookup({27'h055_51FF, 12'hFFF}, 16'd1, "R7");
        do_lookup({27'h055_5200, 12'h000}, 16'd1, "R7");
        do_fill(mk(0, 44'hF00_0000, 8'h0F), 2'd2, 27'h3F8_0000, 16'd1, 0, "R7");
        do_lookup({27'h3F8_3FFF, 12'h001}, 16'd1, "R7");
        // R4 and R5: 64 KiB region, both ends and just outside
        do_flush();
        do_lookup({27'h123_4567, 12'h000}, 16'd1, "R1");
        do_fill(mk(1, 44'h99_9998, 8'hC3), 2'd0, 27'h020_1237, 16'd5, 0, "R4");
        do_lookup({27'h020_1230, 12'h000}, 16'd5, "R4");
        do_lookup({27'h020_123F, 12'hFFF}, 16'd5, "R5");
        do_lookup({27'h020_1237, 12'h444}, 16'd5, "R5");
        do_lookup({27'h020_1240, 12'h000}, 16'd5, "R4");
        do_lookup({27'h020_122F, 12'hFFF}, 16'd5, "R4");
        // R2: illegal entries
        do_fill(mk(0, 44'h1, 8'h0A), 2'd0, 27'h111_1111, 16'd1, 0, "R2");
        do_fill(mk(0, 44'h1, 8'h05), 2'd0, 27'h111_1111, 16'd1, 0, "R2");
        do_fill(mk(0, 44'h1, 8'h03) | 64'h0040_0000_0000_0000, 2'd0, 27'h111_1111, 16'd1, 0, "R2");
        do_fill(mk(0, 44'h1, 8'h03), 2'd3, 27'h111_1111, 16'd1, 0, "R2");
        do_lookup({27'h111_1111, 12'h000}, 16'd1, "R2");
        // R3: bad contiguous encodings
        do_fill(mk(1, 44'h8, 8'h01), 2'd0, 27'h222_2222, 16'd1, 0, "R3");
        do_fill(mk(1, 44'h8, 8'h03), 2'd1, 27'h222_2222, 16'd1, 0, "R3");
        do_fill(mk(1, 44'h9, 8'h03), 2'd0, 27'h222_2222, 16'd1, 0, "R3");
        do_lookup({27'h222_2222, 12'h000}, 16'd1, "R3");
        // R1: flush beats fill in the same cycle
        do_fill(mk(0, 44'h5, 8'h03), 2'd0, 27'h333_3333, 16'd1, 1, "R1");
        do_lookup({27'h333_3333, 12'h000}, 16'd1, "R1");
        do_lookup({27'h020_1230, 12'h000}, 16'd5, "R1");
        // R10: overlapping entries, lowest index wins
        do_fill(mk(0, 44'hA00_0000, 8'h03), 2'd2, 27'h040_0000, 16'd1, 0, "R10");
        do_fill(mk(0, 44'hBBB_BBBB, 8'h07), 2'd0, 27'h040_0123, 16'd1, 0, "R10");
        do_lookup({27'h040_0123, 12'h000}, 16'd1, "R10");
        // R9: fill to full, then round-robin eviction
        do_flush();
        for (int i = 0; i < 10; i++)
            do_fill(mk(0, 44'(i + 16), 8'h03), 2'd0, 27'(i + 27'h100), 16'd1, 0, "R9");
        for (int i = 0; i < 10; i++)
            do_lookup({27'(i + 27'h100), 12'h000}, 16'd1, "R9");
        // Random mix against the model
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) begin
                logic [1:0] lvl;
                bit n;
                lvl = 2'($urandom_range(0, 2));
                n = (lvl == 0) && ($urandom_range(0, 1) == 1);
                p = mk(n, {$urandom, 12'($urandom)}, {2'b00, 1'($urandom), 2'($urandom), 1'($urandom), 1'b1, 1'b1});
                if (n) p[13:10] = 4'b1000;
                if ($urandom_range(0, 9) == 0) p[63:54] = 10'($urandom);
                vpn = {4'($urandom_range(0, 1)), 23'($urandom)} & 27'h0_03FF_FFF;
                do_fill(p, lvl, vpn, 16'($urandom_range(1, 2)), 0,
                        n ? "R4" : (lvl != 0 ? "R7" : "R6"));
            end else begin
                if (m_valid[sel]) va = {m_vpn[sel] ^ 27'($urandom_range(0, 31)), 12'($urandom)};
                else              va = {27'($urandom) & 27'h0_03FF_FFF, 12'($urandom)};
                do_lookup(va, 16'($urandom_range(1, 2)), m_valid[sel] && m_64k[sel] ? "R5" : "R10");
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule